// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Controller

This block sits beside the execute stage of an in-order five-stage pipeline. Each cycle it compares the two source register numbers of the instruction in execute with the destination register numbers of the two older instructions still in flight. For each ALU operand it produces a 2-bit select code that tells the datapath multiplexer which value to take: the register file value, the ALU result held between execute and memory, or the value being written back. With these codes, an instruction that depends on the result of the one just ahead of it runs without a wait.

A load that is followed at once by an instruction using the loaded register cannot be covered by a bypass, because the data only exists after the memory stage. The block checks for this case by comparing the destination of a load in execute with both source fields of the instruction in decode. A store's data register counts as a source. When the case is found, the block asserts a hold for the PC and the fetch/decode register, together with a bubble insert for execute, for one cycle. After that one-cycle gap, the loaded value reaches the consumer by the write-back bypass.

The register file is expected to write early in a cycle and read late in the same cycle. A consumer three instructions behind its producer therefore reads the new value directly and needs no bypass.

Top module: `bypass_hazard_ctl`

## Requirements
- R1: A select output is 2'b10 (memory-stage ALU result) when the memory-stage write enable is set, its destination is nonzero, and that destination equals the operand's source register.
- R2: A select output is 2'b01 (write-back value) when the write-back stage matches the source under the same conditions and the memory stage does not.
- R3: When both stages match the same nonzero source, the memory-stage value is selected (2'b10).
- R4: A select output is 2'b00 (register file) when the source register is 0, or when no stage with its write enable set matches it. This includes a producer that has already left write-back.
- R5: Operand A uses only `ex_src_a` and operand B uses only `ex_src_b`. The two selections do not affect each other.
- R6: `hold` rises when the execute-stage memory-read flag is set, the execute destination is nonzero, and that destination equals either decode source field.
- R7: `bubble` equals `hold` in every cycle.
- R8: With the memory-read flag clear, no stall is raised. A back-to-back ALU dependence relies on bypassing alone.
- R9: A stall lasts exactly one cycle. In the cycle after `hold` is high, `hold` is low even if the inputs still show the load-use pattern.
- R10: After reset with idle inputs, both selects are 2'b00 and `hold`/`bubble` are low.
- R11: After the one-cycle stall, when the load reaches write-back and the consumer reaches execute, the consumer's operand select is 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ex_src_a | input | RW | First source register of the instruction in execute |
| ex_src_b | input | RW | Second source register of the instruction in execute |
| dec_src_a | input | RW | First source register of the instruction in decode |
| dec_src_b | input | RW | Second source register (or store data) of the instruction in decode |
| ex_dst | input | RW | Destination register of the instruction in execute |
| ex_is_load | input | 1 | Instruction in execute reads data memory |
| mem_dst | input | RW | Destination register in the memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | RW | Destination register in the write-back stage |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| sel_a | output | 2 | Operand A source: 00 register file, 10 memory-stage result, 01 write-back value |
| sel_b | output | 2 | Operand B source, same encoding |
| hold | output | 1 | Freeze PC and the fetch/decode register |
| bubble | output | 1 | Insert a no-op into execute |

## Verification
The assertions assume that the pipeline obeys `bubble`. After a stall, the execute stage therefore holds a no-op, so a second stall can come only from a new load. The assertions also assume that the register fields are stable between clock edges. The stimulus drives every input on the falling edge and holds it for a full cycle. It separates the stall vectors with an idle cycle, so each vector starts with the one-cycle guard clear. Only the directed test of R9 keeps a load-use pattern in place across an edge, and it does so on purpose.

// File: rtl/bypass_hazard_ctl.sv
module bypass_hazard_ctl #(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_is_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic          hold,
  output logic          bubble
);
  localparam logic [RW-1:0] ZERO = '0;

  logic mem_live, wb_live, load_use, stalled_q;

  assign mem_live = mem_wr && (mem_dst != ZERO);
  assign wb_live  = wb_wr  && (wb_dst  != ZERO);

  function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                      input logic m_ok, input logic [RW-1:0] m_dst,
                                      input logic w_ok, input logic [RW-1:0] w_dst);
    if (m_ok && m_dst == src)      return 2'b10;
    else if (w_ok && w_dst == src) return 2'b01;
    else                           return 2'b00;
  endfunction

  assign sel_a = pick(ex_src_a, mem_live, mem_dst, wb_live, wb_dst);
  assign sel_b = pick(ex_src_b, mem_live, mem_dst, wb_live, wb_dst);

  assign load_use = ex_is_load && (ex_dst != ZERO) &&
                    ((ex_dst == dec_src_a) || (ex_dst == dec_src_b));

  always_ff @(posedge clk) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= hold;
  end

  assign hold   = load_use && !stalled_q;
  assign bubble = hold;
endmodule

module bypass_hazard_ctl_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [RW-1:0] ex_src_a,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic [RW-1:0] wb_dst,
  input logic          wb_wr,
  input logic          ex_is_load,
  input logic [1:0]    sel_a,
  input logic          hold
);
  // R1
  mem_hit_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_dst != '0 && mem_dst == ex_src_a) |-> sel_a == 2'b10);
  // R2
  wb_hit_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mem_wr && mem_dst == ex_src_a) && wb_wr && wb_dst != '0 && wb_dst == ex_src_a)
      |-> sel_a == 2'b01);
  // R4
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_a == '0) |-> sel_a == 2'b00);
  // R8
  no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_load |-> !hold);
  // R9
  single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !hold);
endmodule

bind bypass_hazard_ctl bypass_hazard_ctl_chk #(.RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ex_src_a(ex_src_a), .mem_dst(mem_dst),
  .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr), .ex_is_load(ex_is_load),
  .sel_a(sel_a), .hold(hold));

// File: tb/bypass_hazard_ctl_tb.sv
`timescale 1ns/1ps
module bypass_hazard_ctl_tb_top;
  localparam int RW = 2;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [RW-1:0] ex_src_a, ex_src_b, dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst;
  logic ex_is_load, mem_wr, wb_wr;
  logic [1:0] sel_a, sel_b;
  logic hold, bubble;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bypass_hazard_ctl #(.RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .ex_dst(ex_dst),
    .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_wr(mem_wr),
    .wb_dst(wb_dst), .wb_wr(wb_wr), .sel_a(sel_a), .sel_b(sel_b),
    .hold(hold), .bubble(bubble));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(input int src);
    if (mem_wr && mem_dst != 0 && mem_dst == src) return 2;
    if (wb_wr && wb_dst != 0 && wb_dst == src) return 1;
    return 0;
  endfunction

  function automatic string sel_tag(input int src);
    bit m = mem_wr && mem_dst != 0 && mem_dst == src;
    bit w = wb_wr && wb_dst != 0 && wb_dst == src;
    if (m && w) return "R3";
    if (m) return "R1";
    if (w) return "R2";
    return "R4";
  endfunction

  task automatic idle();
    ex_src_a = 0; ex_src_b = 0; dec_src_a = 0; dec_src_b = 0; ex_dst = 0;
    ex_is_load = 0; mem_dst = 0; mem_wr = 0; wb_dst = 0; wb_wr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 sel_a", sel_a, 0); chk("R10 sel_b", sel_b, 0);
    chk("R10 hold", hold, 0);   chk("R10 bubble", bubble, 0);

    // forwarding sweep: operand B always reads the register operand A does not
    for (int a = 0; a < 4; a++)
      for (int md = 0; md < 4; md++)
        for (int mw = 0; mw < 2; mw++)
          for (int wd = 0; wd < 4; wd++)
            for (int ww = 0; ww < 2; ww++) begin
              @(negedge clk);
              ex_src_a = RW'(a); ex_src_b = RW'(3 - a);
              mem_dst = RW'(md); mem_wr = mw[0]; wd_set(wd, ww);
              #1;
              chk({sel_tag(a), " sel_a"}, sel_a, exp_sel(a));
              chk({"R5 ", sel_tag(3 - a), " sel_b"}, sel_b, exp_sel(3 - a));
              chk("R8 hold without load", hold, 0);
            end

    // load-use sweep, each vector followed by an idle cycle
    idle();
    for (int d = 0; d < 4; d++)
      for (int ld = 0; ld < 2; ld++)
        for (int s1 = 0; s1 < 4; s1++)
          for (int s2 = 0; s2 < 4; s2++) begin
            @(negedge clk);
            ex_dst = RW'(d); ex_is_load = ld[0];
            dec_src_a = RW'(s1); dec_src_b = RW'(s2);
            #1;
            chk(ld ? "R6 hold" : "R8 hold", hold,
                (ld && d != 0 && (d == s1 || d == s2)) ? 1 : 0);
            chk("R7 bubble", bubble, hold);
            @(negedge clk);
            ex_is_load = 0;
            #1;
            chk("R8 idle hold", hold, 0);
          end

    // R9: load-use pattern held across an edge
    @(negedge clk);
    ex_dst = 2; ex_is_load = 1; dec_src_a = 0; dec_src_b = 2;
    #1; chk("R9 first cycle hold", hold, 1);
    @(negedge clk); #1;
    chk("R9 second cycle hold", hold, 0);
    chk("R9 second cycle bubble", bubble, 0);

    // R11: load r2, then consumer of r2; pipeline modelled by the bench
    idle();
    @(negedge clk);
    ex_dst = 2; ex_is_load = 1; dec_src_a = 2; dec_src_b = 1;
    #1; chk("R11 stall raised", hold, 1);
    @(negedge clk);
    idle(); mem_dst = 2; mem_wr = 1; dec_src_a = 2; dec_src_b = 1;
    #1; chk("R11 no second stall", hold, 0);
    @(negedge clk);
    idle(); wb_dst = 2; wb_wr = 1; ex_src_a = 2; ex_src_b = 1;
    #1;
    chk("R11 sel_a", sel_a, 1);
    chk("R11 mux operand", (sel_a == 2'b10) ? 22 : (sel_a == 2'b01) ? 33 : 11, 33);
    chk("R11 sel_b", sel_b, 0);

    // R4: fourth instruction of a chain, producer already retired
    @(negedge clk);
    idle(); ex_src_a = 1; ex_src_b = 1; mem_dst = 3; mem_wr = 1; wb_dst = 2; wb_wr = 1;
    #1; chk("R4 chain sel_a", sel_a, 0); chk("R4 chain sel_b", sel_b, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic wd_set(input int wd, input int ww);
    wb_dst = RW'(wd); wb_wr = ww[0];
  endtask
endmodule